// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings so that most memory accesses skip the page-table walk. A requester presents a 32-bit virtual address and an access kind through a valid/ready handshake. One cycle later the block either answers from its storage or starts a walk. An answer carries the physical address, which is the stored physical page number joined to the untranslated 12-bit page offset. If the access kind is not permitted, the answer is a protection fault instead.

On a miss the block asks an external page-table walker for the mapping of the virtual page number. It installs the returned mapping and then repeats the lookup. If the walker says the mapping is unusable, no entry is written and a page fault is returned. A write that hits a clean entry marks the entry dirty and sends a dirty-update request to the walker before the access completes. Two maintenance inputs keep the cache coherent with memory. A strobe written when the page-table base changes empties the whole buffer. A targeted invalidate removes the single entry whose virtual page number matches.

Storage is 4-way set associative, and each set keeps its own least-recently-used age order. Only one request is in flight at a time. New requests are held off until the current one has been answered.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup that hits answers with rspValid high in the cycle right after the request is accepted, with rspStatus 2'b00 and rspPaddr equal to the stored page number followed by reqVaddr[11:0].
- R2: A miss raises walkReqValid with walkReqDirty low and walkReqVpn equal to reqVaddr[31:12]. The request is held steady until walkRspValid. The returned mapping is then installed, and the repeated lookup answers with status 2'b00.
- R3: A walker response with walkRspFault high answers in that same cycle with rspStatus 2'b01 and installs nothing, so the same page walks again next time.
- R4: A baseWrite pulse clears every entry. A baseWrite in the compare cycle turns that compare into a miss. A baseWrite during a walk discards that walk's fill, so the retry walks again.
- R5: An invalidate carrying a virtual page number removes only the matching entry. Other entries in the same set still hit, and a page number that is not present changes nothing.
- R6: The set index is VPN[3:0] (default of 16 sets). A fill uses an invalid way first, otherwise the least-recently-used way. Any hit or fill makes its way the most recent.
- R7: Permission bits are walkRspPerm[0] read, [1] write and [2] execute, and reqAccess is 0 read, 1 write, 2 execute. A hit whose access bit is clear, or any hit with reqAccess 3, answers with rspStatus 2'b10.
- R8: A permitted write that hits an entry whose dirty bit is clear sets that bit. It raises walkReqValid with walkReqDirty high for that page, and completes with status 2'b00 after the walker acknowledges. Later writes to that page raise no walk.
- R9: reqReady is low from the cycle after a request is accepted until the response cycle has passed. reqReady is never high while walkReqValid is high.
- R10: After reset reqReady is high, walkReqValid and rspValid are low, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block can accept a lookup |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rspValid | output | 1 | Response present for one cycle |
| rspStatus | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rspPaddr | output | 32 | Physical address (valid with status 00) |
| walkReqValid | output | 1 | Walk or dirty-update request |
| walkReqVpn | output | 20 | Virtual page number to walk |
| walkReqDirty | output | 1 | High: dirty-bit update, low: translation fetch |
| walkRspValid | input | 1 | Walker answer, one cycle |
| walkRspFault | input | 1 | Mapping invalid or page not resident |
| walkRspPpn | input | 20 | Returned physical page number |
| walkRspPerm | input | 3 | Returned permissions {X,W,R} |
| walkRspDirty | input | 1 | Returned dirty bit |
| baseWrite | input | 1 | Page-table base written: flush all |
| invValid | input | 1 | Single-entry invalidate strobe |
| invVpn | input | 20 | Page number to invalidate |

## Verification
Maintenance can collide with the compare or the fill. The bench raises baseWrite in exactly the cycle where a resident page is compared. That lookup must then walk once and still return the correct translation. It also raises baseWrite while a walk is outstanding, and that must cost a second walk because the first fill is dropped. Random traffic mixes flushes and invalidates between lookups. Every answer is judged against status and address functions of the page number. Walk counts on directed sequences expose hits, misses and eviction order.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] RSP_OK     = 2'b00;
  localparam logic [1:0] RSP_PFAULT = 2'b01;
  localparam logic [1:0] RSP_PROT   = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch the incoming request
    logic touch;      // refresh LRU age of the hit way
    logic fill;       // install walker mapping into victim way
    logic markDirty;  // set dirty bit of the hit way
  } ctrl_strobe_t;
endpackage

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int WAYS        = 4,
  parameter int PPN_W       = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobe,
  input  logic [VA_W-1:0]        reqVaddr,
  input  logic [1:0]             reqAccess,
  input  logic                   flushAll,
  input  logic                   invValid,
  input  logic [VPN_W-1:0]       invVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic [2:0]             fillPerm,
  input  logic                   fillDirty,
  output logic                   hit,
  output logic                   permOk,
  output logic                   needDirty,
  output logic [VPN_W-1:0]       curVpn,
  output logic [PPN_W+OFF_W-1:0] paddr
);
  localparam int SETS  = NUM_ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  validQ [SETS];
  logic [WAYS-1:0]  dirtyQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [PPN_W-1:0] ppnQ   [SETS][WAYS];
  logic [2:0]       permQ  [SETS][WAYS];
  logic [WAY_W-1:0] ageQ   [SETS][WAYS];

  logic [VA_W-1:0]  vaQ;
  logic [1:0]       accQ;

  logic [IDX_W-1:0] curIdx, invIdx;
  logic [TAG_W-1:0] curTag, invTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, victim, touchWay;
  logic             foundInv, blocked;
  logic [2:0]       selPerm;
  logic [PPN_W-1:0] selPpn;

  assign curVpn = vaQ[VA_W-1:OFF_W];
  assign curIdx = curVpn[IDX_W-1:0];
  assign curTag = curVpn[VPN_W-1:IDX_W];
  assign invIdx = invVpn[IDX_W-1:0];
  assign invTag = invVpn[VPN_W-1:IDX_W];

  // tag compare; maintenance in the same cycle wins over the compare
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitVec[w] = validQ[curIdx][w] && (tagQ[curIdx][w] == curTag);
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
    blocked = flushAll || (invValid && (invVpn == curVpn));
    hit     = (|hitVec) && !blocked;
    selPerm = permQ[curIdx][hitWay];
    selPpn  = ppnQ[curIdx][hitWay];
    case (accQ)
      ACC_READ:  permOk = selPerm[0];
      ACC_WRITE: permOk = selPerm[1];
      ACC_EXEC:  permOk = selPerm[2];
      default:   permOk = 1'b0;
    endcase
    needDirty = (accQ == ACC_WRITE) && !dirtyQ[curIdx][hitWay];
    paddr     = {selPpn, vaQ[OFF_W-1:0]};
  end

  // victim: lowest invalid way, else the oldest way
  always_comb begin
    victim   = '0;
    foundInv = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!validQ[curIdx][w] && !foundInv) begin
        victim   = WAY_W'(w);
        foundInv = 1'b1;
      end
    end
    if (!foundInv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ageQ[curIdx][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  assign touchWay = strobe.fill ? victim : hitWay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ  <= '0;
      accQ <= '0;
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        dirtyQ[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageQ[s][w] <= WAY_W'(w);
      end
    end else begin
      if (strobe.capture) begin
        vaQ  <= reqVaddr;
        accQ <= reqAccess;
      end
      if (strobe.fill) begin
        validQ[curIdx][victim] <= 1'b1;
        dirtyQ[curIdx][victim] <= fillDirty;
      end
      if (strobe.markDirty) dirtyQ[curIdx][hitWay] <= 1'b1;
      if (strobe.fill || strobe.touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageQ[curIdx][w] <= '0;
          else if (ageQ[curIdx][w] < ageQ[curIdx][touchWay])
            ageQ[curIdx][w] <= ageQ[curIdx][w] + 1'b1;
        end
      end
      if (invValid) begin
        for (int w = 0; w < WAYS; w++) begin
          if (tagQ[invIdx][w] == invTag) validQ[invIdx][w] <= 1'b0;
        end
      end
      if (flushAll) begin
        for (int s = 0; s < SETS; s++) validQ[s] <= '0;
      end
    end
  end

  // payload fields carry no reset
  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagQ[curIdx][victim]  <= curTag;
      ppnQ[curIdx][victim]  <= fillPpn;
      permQ[curIdx][victim] <= fillPerm;
    end
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         hit,
  input  logic         permOk,
  input  logic         needDirty,
  input  logic         flushAll,
  input  logic         walkRspValid,
  input  logic         walkRspFault,
  output ctrl_strobe_t strobe,
  output logic         walkReqValid,
  output logic         walkReqDirty,
  output logic         rspValid,
  output logic [1:0]   rspStatus
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK, S_DWALK} state_e;
  state_e stateQ, stateD;
  logic   dropQ;

  always_comb begin
    stateD       = stateQ;
    strobe       = '0;
    reqReady     = 1'b0;
    walkReqValid = 1'b0;
    walkReqDirty = 1'b0;
    rspValid     = 1'b0;
    rspStatus    = RSP_OK;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateD         = S_LOOK;
        end
      end
      S_LOOK: begin
        if (hit) begin
          strobe.touch = 1'b1;
          if (!permOk) begin
            rspValid  = 1'b1;
            rspStatus = RSP_PROT;
            stateD    = S_IDLE;
          end else if (needDirty) begin
            strobe.markDirty = 1'b1;
            stateD           = S_DWALK;
          end else begin
            rspValid = 1'b1;
            stateD   = S_IDLE;
          end
        end else begin
          stateD = S_WALK;
        end
      end
      S_WALK, S_DWALK: begin
        walkReqValid = 1'b1;
        walkReqDirty = (stateQ == S_DWALK);
        if (walkRspValid) begin
          if (walkRspFault) begin
            rspValid  = 1'b1;
            rspStatus = RSP_PFAULT;
            stateD    = S_IDLE;
          end else begin
            strobe.fill = (stateQ == S_WALK) && !dropQ && !flushAll;
            stateD      = S_LOOK;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      dropQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_LOOK) dropQ <= 1'b0;
      else if (flushAll && (stateQ == S_WALK)) dropQ <= 1'b1;
    end
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int WAYS        = 4,
  parameter int PPN_W       = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [31:0]            reqVaddr,
  input  logic [1:0]             reqAccess,
  output logic                   rspValid,
  output logic [1:0]             rspStatus,
  output logic [PPN_W+11:0]      rspPaddr,
  output logic                   walkReqValid,
  output logic [19:0]            walkReqVpn,
  output logic                   walkReqDirty,
  input  logic                   walkRspValid,
  input  logic                   walkRspFault,
  input  logic [PPN_W-1:0]       walkRspPpn,
  input  logic [2:0]             walkRspPerm,
  input  logic                   walkRspDirty,
  input  logic                   baseWrite,
  input  logic                   invValid,
  input  logic [19:0]            invVpn
);
  ctrl_strobe_t strobe;
  logic hit, permOk, needDirty;

  xlat_ctrl ctrl_i (
    .clk, .rstN, .reqValid, .reqReady,
    .hit, .permOk, .needDirty,
    .flushAll(baseWrite),
    .walkRspValid, .walkRspFault,
    .strobe, .walkReqValid, .walkReqDirty,
    .rspValid, .rspStatus
  );

  xlat_dpath #(.NUM_ENTRIES(NUM_ENTRIES), .WAYS(WAYS), .PPN_W(PPN_W)) dpath_i (
    .clk, .rstN, .strobe,
    .reqVaddr, .reqAccess,
    .flushAll(baseWrite), .invValid, .invVpn,
    .fillPpn(walkRspPpn), .fillPerm(walkRspPerm), .fillDirty(walkRspDirty),
    .hit, .permOk, .needDirty,
    .curVpn(walkReqVpn), .paddr(rspPaddr)
  );
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic [1:0]  rspStatus,
  input logic        walkReqValid,
  input logic [19:0] walkReqVpn,
  input logic        walkReqDirty,
  input logic        walkRspValid,
  input logic        walkRspFault,
  input logic        baseWrite
);
  // R9: no acceptance while a walk is outstanding
  p_ready_vs_walk_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && walkReqValid));

  // R9: busy right after acceptance
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: a response never overlaps readiness
  p_rsp_when_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R2: walk request held steady until answered
  p_walk_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (walkReqValid && !walkRspValid) |=>
      (walkReqValid && $stable(walkReqVpn) && $stable(walkReqDirty)));

  // R3: walker fault turns into a page-fault response at once
  p_fault_reported_r3: assert property (@(posedge clk) disable iff (!rstN)
    (walkReqValid && walkRspValid && walkRspFault) |-> (rspValid && rspStatus == 2'b01));

  // R4: a flush cycle never delivers a successful translation
  p_flush_no_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    baseWrite |-> !(rspValid && rspStatus == 2'b00));
endmodule

bind xlat_buffer xlat_buffer_chk chk_i (
  .clk, .rstN, .reqValid, .reqReady, .rspValid, .rspStatus,
  .walkReqValid, .walkReqVpn, .walkReqDirty,
  .walkRspValid, .walkRspFault, .baseWrite
);

// File: tb/xlat_buffer_tb_top.sv
module xlat_buffer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rstN;
  logic        reqValid, reqReady;
  logic [31:0] reqVaddr;
  logic [1:0]  reqAccess;
  logic        rspValid;
  logic [1:0]  rspStatus;
  logic [31:0] rspPaddr;
  logic        walkReqValid, walkReqDirty;
  logic [19:0] walkReqVpn;
  logic        walkRspValid, walkRspFault, walkRspDirty;
  logic [19:0] walkRspPpn;
  logic [2:0]  walkRspPerm;
  logic        baseWrite, invValid;
  logic [19:0] invVpn;

  int checks = 0;
  int fails  = 0;
  int walkCount = 0;
  bit lastDirty = 0;

  xlat_buffer dut_i (
    .clk, .rstN, .reqValid, .reqReady, .reqVaddr, .reqAccess,
    .rspValid, .rspStatus, .rspPaddr,
    .walkReqValid, .walkReqVpn, .walkReqDirty,
    .walkRspValid, .walkRspFault, .walkRspPpn, .walkRspPerm, .walkRspDirty,
    .baseWrite, .invValid, .invVpn
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // page-table model
  function automatic logic isFault(input logic [19:0] v);
    return v[19];
  endfunction
  function automatic logic [2:0] permOf(input logic [19:0] v);
    return {v[18] ^ v[17], ~v[17], ~v[18]};   // {X,W,R}
  endfunction
  function automatic logic [19:0] ppnOf(input logic [19:0] v);
    return v ^ 20'h5A3C1;
  endfunction
  function automatic logic [1:0] expStatus(input logic [19:0] v, input logic [1:0] acc);
    logic [2:0] p;
    p = permOf(v);
    if (isFault(v)) return 2'b01;
    if (acc == 2'd3) return 2'b10;
    return p[acc] ? 2'b00 : 2'b10;
  endfunction

  task automatic chkEq(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // walker: answers two cycles after it sees a request
  initial begin
    walkRspValid = 0; walkRspFault = 0; walkRspPpn = '0;
    walkRspPerm = '0; walkRspDirty = 0;
    forever begin
      @(negedge clk);
      if (walkReqValid) begin
        logic [19:0] v;
        v = walkReqVpn;
        walkCount++;
        lastDirty = walkReqDirty;
        repeat (2) @(negedge clk);
        walkRspValid = 1; walkRspFault = isFault(v);
        walkRspPpn = ppnOf(v); walkRspPerm = permOf(v); walkRspDirty = 0;
        @(negedge clk);
        walkRspValid = 0;
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input bit flushAtCompare,
                        output logic [1:0] st, output logic [31:0] pa,
                        output int walks, output int lat, output bit stayedBusy);
    int w0;
    w0 = walkCount;
    @(negedge clk);
    reqVaddr = va; reqAccess = acc; reqValid = 1;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    reqValid = 0; lat = 1; stayedBusy = 1;
    if (flushAtCompare) baseWrite = 1;
    #1;
    while (!rspValid) begin
      if (reqReady) stayedBusy = 0;
      @(negedge clk);
      if (flushAtCompare) baseWrite = 0;
      #1;
      lat++;
    end
    st = rspStatus; pa = rspPaddr; walks = walkCount - w0;
    if (flushAtCompare && baseWrite) begin @(posedge clk); #1 baseWrite = 0; end
  endtask

  task automatic pulseFlush();
    @(negedge clk); baseWrite = 1;
    @(negedge clk); baseWrite = 0;
  endtask

  task automatic pulseInv(input logic [19:0] v);
    @(negedge clk); invValid = 1; invVpn = v;
    @(negedge clk); invValid = 0;
  endtask

  function automatic logic [31:0] mkVa(input logic [19:0] v, input logic [11:0] off);
    return {v, off};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=hang expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [1:0]  st;
    logic [31:0] pa;
    int walks, lat;
    bit busy;
    logic [19:0] vA, vB, vC;

    reqValid = 0; reqVaddr = '0; reqAccess = '0;
    baseWrite = 0; invValid = 0; invVpn = '0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chkEq("R10", "reqReady after reset", reqReady, 1);
    chkEq("R10", "walkReqValid after reset", walkReqValid, 0);
    chkEq("R10", "rspValid after reset", rspValid, 0);

    // R2 / R10: first lookup misses and walks
    vA = 20'h00012;
    lookup(mkVa(vA, 12'h345), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R10", "walks on empty buffer", walks, 1);
    chkEq("R2", "status after fill", st, 2'b00);
    chkEq("R2", "paddr after fill", pa, {ppnOf(vA), 12'h345});
    chkEq("R9", "reqReady low until response", busy, 1);

    // R1: hit, one cycle
    lookup(mkVa(vA, 12'hABC), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R1", "hit walks", walks, 0);
    chkEq("R1", "hit latency", lat, 1);
    chkEq("R1", "hit paddr", pa, {ppnOf(vA), 12'hABC});

    // R8: first write to clean entry triggers dirty update
    lookup(mkVa(vA, 12'h010), 2'd1, 0, st, pa, walks, lat, busy);
    chkEq("R8", "dirty update walks", walks, 1);
    chkEq("R8", "dirty flag on walk", lastDirty, 1);
    chkEq("R8", "write status", st, 2'b00);
    lookup(mkVa(vA, 12'h020), 2'd1, 0, st, pa, walks, lat, busy);
    chkEq("R8", "second write walks", walks, 0);

    // R7: protection
    lookup(mkVa(20'h40003, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R7", "read without R", st, 2'b10);
    lookup(mkVa(20'h40003, 12'h0), 2'd2, 0, st, pa, walks, lat, busy);
    chkEq("R7", "exec with X", st, 2'b00);
    chkEq("R7", "exec on resident walks", walks, 0);
    lookup(mkVa(vA, 12'h0), 2'd3, 0, st, pa, walks, lat, busy);
    chkEq("R7", "access code 3", st, 2'b10);

    // R3: page fault, no fill
    lookup(mkVa(20'h80005, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R3", "fault status", st, 2'b01);
    lookup(mkVa(20'h80005, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R3", "fault not installed", walks, 1);

    // R5: targeted invalidate
    vA = 20'h00021; vB = 20'h00031;
    lookup(mkVa(vA, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    lookup(mkVa(vB, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    pulseInv(vA);
    pulseInv(20'h00041);
    lookup(mkVa(vB, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R5", "other entry kept", walks, 0);
    lookup(mkVa(vA, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R5", "matching entry removed", walks, 1);

    // R4: flush variants
    pulseFlush();
    lookup(mkVa(vB, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R4", "flush empties buffer", walks, 1);
    lookup(mkVa(vB, 12'h777), 2'd0, 1, st, pa, walks, lat, busy);
    chkEq("R4", "flush at compare forces walk", walks, 1);
    chkEq("R4", "flush at compare paddr", pa, {ppnOf(vB), 12'h777});
    vC = 20'h00051;
    fork
      lookup(mkVa(vC, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
      begin
        wait (walkReqValid);
        @(negedge clk); baseWrite = 1;
        @(negedge clk); baseWrite = 0;
      end
    join
    chkEq("R4", "flush during walk drops fill", walks, 2);
    chkEq("R4", "status after dropped fill", st, 2'b00);

    // R6: LRU in set 0
    for (int k = 1; k <= 4; k++)
      lookup(mkVa(20'(k << 4), 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    lookup(mkVa(20'h00010, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "four ways resident", walks, 0);
    lookup(mkVa(20'h00050, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "fifth page walks", walks, 1);
    lookup(mkVa(20'h00010, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "recently used kept", walks, 0);
    lookup(mkVa(20'h00020, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "oldest evicted", walks, 1);
    lookup(mkVa(20'h00040, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "younger kept", walks, 0);
    lookup(mkVa(20'h00030, 12'h0), 2'd0, 0, st, pa, walks, lat, busy);
    chkEq("R6", "next oldest evicted", walks, 1);

    // random traffic
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [19:0] v;
      logic [1:0]  acc;
      logic [11:0] off;
      r   = $urandom;
      v   = {r[2:0], 13'b0, r[6:3]};
      acc = r[8:7];
      off = r[20:9];
      if (r[31:28] == 4'd0) pulseFlush();
      else if (r[31:28] == 4'd1) pulseInv({r[23:21], 13'b0, r[27:24]});
      lookup(mkVa(v, off), acc, 0, st, pa, walks, lat, busy);
      chkEq(acc == 2'd1 ? "R8" : "R7", "random status", st, expStatus(v, acc));
      if (expStatus(v, acc) == 2'b00)
        chkEq("R1", "random paddr", pa, {ppnOf(v), off});
    end

    summary();
    $finish;
  end
endmodule